// File: doc/BRIEF.md
# Distributed Priority Bus Arbitration Node

This block is the bus-access controller placed inside each of four devices that share one synchronous bus. No central arbiter exists. Every node watches all four request lines and decides locally, on each clock edge, whether it owns the bus in the next cycle. Each node is built with a fixed priority from 1 to 4, and a higher number wins.

A device asks for the bus through a local request strobe. The node then raises its own line on the shared request wires and keeps it raised until it wins. A bus transfer lasts exactly one cycle. The winning node shows mastership for that single cycle with its request line low, and then sits out one back-off cycle. Because of that back-off cycle, no device can own the bus on two consecutive cycles. An external busy line stops all arbitration while it is high. Both node outputs are decoded from the state register alone. Under sustained traffic from higher-priority devices, a low-priority node can wait for ever. This is expected behaviour and not a fault.

Top module: `bus_arb_node`

## Requirements
- R1: While reset is applied, and for the cycles before reset is released internally, `req_o` and `master_o` are low.
- R2: If `dev_req_i` is high in an idle node at a clock edge, `req_o` is high in the cycle that follows.
- R3: Bit i of `bus_req_i` belongs to the device of priority i+1. If a node drives `req_o` high, `bus_busy_i` is low and no bit of `bus_req_i` above its own is set, `master_o` is high in the next cycle.
- R4: A node with `req_o` high that does not win keeps `req_o` high in the next cycle, even if `dev_req_i` has dropped.
- R5: `master_o` stays high for one cycle only, and `req_o` is low during that cycle.
- R6: The cycle after a mastership cycle is a back-off cycle, with `req_o` and `master_o` both low. After it, the node requests again if `dev_req_i` is high, and otherwise it goes idle.
- R7: While `bus_busy_i` is high, no requesting node becomes master, and every pending request stays asserted.
- R8: In a system of four nodes, at most one node is master in any cycle. When several nodes are pending, they are served in descending priority order, one per cycle.
- R9: If the devices of priorities 2 to 4 request continuously, the priority-1 device is never granted the bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dev_req_i | input | 1 | Local device wants the bus |
| bus_req_i | input | N_DEV | All shared request lines, bit i = priority i+1 |
| bus_busy_i | input | 1 | Bus held elsewhere; suspends arbitration |
| req_o | output | 1 | This node's request line |
| master_o | output | 1 | This node owns the bus this cycle |

## Verification
Every result lands a fixed number of edges after its cause, because each output is decoded from a single state register:
- a local request shows on the request line one edge after it is sampled;
- the winner of an arbitration is master one edge after that;
- back-off follows one edge after mastership;
- after back-off, the node is idle or requesting again one edge later.

The bench drives inputs on the falling edge and reads outputs on the next falling edge, so each check lands exactly one edge after its cause. In the request-pattern sweep, the k-th highest pending device must be the only master after the k-th arbitration edge.

// File: rtl/bus_arb_pkg.sv
package bus_arb_pkg;
  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_REQ     = 2'd1,
    ST_MASTER  = 2'd2,
    ST_BACKOFF = 2'd3
  } arb_state_e;
endpackage

// File: rtl/arb_rst_sync.sv
module arb_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] shreg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) shreg <= '0;
    else        shreg <= {shreg[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = shreg[STAGES-1];
endmodule

// File: rtl/arb_win_detect.sv
module arb_win_detect #(
  parameter int N_DEV = 4,
  parameter int PRIO  = 1
) (
  input  logic [N_DEV-1:0] bus_req_i,
  input  logic             busy_i,
  input  logic             requesting_i,
  output logic             win_o
);
  logic [N_DEV-1:0] above_mask;

  // Mask of lines belonging to devices with a higher priority number.
  for (genvar i = 0; i < N_DEV; i++) begin : g_mask
    if (i >= PRIO) begin : g_hi
      assign above_mask[i] = 1'b1;
    end else begin : g_lo
      assign above_mask[i] = 1'b0;
    end
  end

  assign win_o = requesting_i && !busy_i && ((bus_req_i & above_mask) == '0);
endmodule

// File: rtl/arb_fsm.sv
module arb_fsm
  import bus_arb_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       dev_req_i,
  input  logic       win_i,
  output arb_state_e state_o
);
  arb_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:    if (dev_req_i) state_d = ST_REQ;
      ST_REQ:     if (win_i)     state_d = ST_MASTER;
      ST_MASTER:                 state_d = ST_BACKOFF;
      ST_BACKOFF: state_d = dev_req_i ? ST_REQ : ST_IDLE;
      default:                   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  assign state_o = state_q;
endmodule

// File: rtl/bus_arb_node.sv
module bus_arb_node
  import bus_arb_pkg::*;
#(
  parameter int N_DEV = 4,
  parameter int PRIO  = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             dev_req_i,
  input  logic [N_DEV-1:0] bus_req_i,
  input  logic             bus_busy_i,
  output logic             req_o,
  output logic             master_o
);
  logic       rst_n_int;
  logic       win;
  arb_state_e state;

  arb_rst_sync #(.STAGES(2)) u_rst (
    .clk       (clk),
    .rst_n     (rst_n),
    .rst_n_sync(rst_n_int)
  );

  arb_win_detect #(.N_DEV(N_DEV), .PRIO(PRIO)) u_win (
    .bus_req_i   (bus_req_i),
    .busy_i      (bus_busy_i),
    .requesting_i(state == ST_REQ),
    .win_o       (win)
  );

  arb_fsm u_fsm (
    .clk      (clk),
    .rst_n    (rst_n_int),
    .dev_req_i(dev_req_i),
    .win_i    (win),
    .state_o  (state)
  );

  // Moore outputs
  assign req_o    = (state == ST_REQ);
  assign master_o = (state == ST_MASTER);
endmodule

// File: rtl/bus_arb_node_chk.sv
module bus_arb_node_chk #(
  parameter int N_DEV = 4,
  parameter int PRIO  = 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic [N_DEV-1:0] bus_req_i,
  input logic             bus_busy_i,
  input logic             req_o,
  input logic             master_o
);
  logic higher_pending;

  always_comb begin
    higher_pending = 1'b0;
    for (int i = PRIO; i < N_DEV; i++) higher_pending = higher_pending | bus_req_i[i];
  end

  assert_win_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_o && !bus_busy_i && !higher_pending) |=> master_o);

  assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_o && higher_pending) |=> (req_o && !master_o));

  assert_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    master_o |-> !req_o);

  assert_backoff_R6: assert property (@(posedge clk) disable iff (!rst_n)
    master_o |=> (!master_o && !req_o));

  assert_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_o && bus_busy_i) |=> (req_o && !master_o));
endmodule

bind bus_arb_node bus_arb_node_chk #(.N_DEV(N_DEV), .PRIO(PRIO)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_req_i (bus_req_i),
  .bus_busy_i(bus_busy_i),
  .req_o     (req_o),
  .master_o  (master_o)
);

// File: tb/bus_arb_node_tb.sv
`timescale 1ns/1ps
module bus_arb_node_tb;
  localparam int N = 4;

  logic         clk = 1'b0;
  logic         rst_n;
  logic [N-1:0] dev_req;
  logic         busy;
  logic [N-1:0] req;
  logic [N-1:0] mst;
  logic [N-1:0] prev_mst;
  int           n_chk = 0;
  int           n_fail = 0;
  bit           done = 0;

  always #4 clk = ~clk;

  for (genvar g = 0; g < N; g++) begin : g_node
    bus_arb_node #(.N_DEV(N), .PRIO(g + 1)) u_dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .dev_req_i (dev_req[g]),
      .bus_req_i (req),
      .bus_busy_i(busy),
      .req_o     (req[g]),
      .master_o  (mst[g])
    );
  end

  task automatic check(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  // One edge, then sample on the falling edge; system invariants R8 each cycle.
  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
    n_chk++;
    if (!$onehot0(mst)) begin
      n_fail++;
      $display("FAIL R8 several masters actual=%b expected=onehot0", mst);
    end
    n_chk++;
    if ((mst & prev_mst) != '0) begin
      n_fail++;
      $display("FAIL R8 consecutive mastership actual=%b expected=%b", mst & prev_mst, 4'b0);
    end
    prev_mst = mst;
  endtask

  function automatic logic [N-1:0] top_bit(input logic [N-1:0] v);
    for (int i = N - 1; i >= 0; i--) if (v[i]) return (4'b1 << i);
    return '0;
  endfunction

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    logic [N-1:0] pend;
    int starve_cnt1, cnt4;
    prev_mst = '0;
    rst_n   = 1'b0;
    dev_req = '0;
    busy    = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 reset req", req, 4'b0);
    check("R1 reset master", mst, 4'b0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 sync release req", req, 4'b0);
    check("R1 sync release master", mst, 4'b0);
    repeat (3) cyc();

    // Sweep of all request patterns: R2, R3, R4, R5, R8
    for (int p = 0; p < 16; p++) begin
      dev_req = p[N-1:0];
      cyc();
      dev_req = '0;
      check("R2 request lines", req, p[N-1:0]);
      pend = p[N-1:0];
      while (pend != '0) begin
        cyc();
        check("R3 R8 priority grant", mst, top_bit(pend));
        pend = pend & ~top_bit(pend);
        check("R4 R5 pending lines", req, pend);
      end
      cyc();
      check("R6 back-off master", mst, 4'b0);
      check("R6 back-off req", req, 4'b0);
      repeat (2) cyc();
    end

    // R6: held request on priority 4
    dev_req = 4'b1000;
    cyc(); check("R2 hold req", req, 4'b1000);
    cyc(); check("R3 hold master", mst, 4'b1000);
    cyc(); check("R6 back-off master", mst, 4'b0000);
    check("R6 back-off req", req, 4'b0000);
    cyc(); check("R6 re-request", req, 4'b1000);
    cyc(); check("R6 second grant", mst, 4'b1000);
    dev_req = '0;
    cyc(); check("R6 back-off after drop", req | mst, 4'b0);
    cyc(); check("R6 idle req", req, 4'b0);
    check("R6 idle master", mst, 4'b0);
    repeat (2) cyc();

    // R7: busy suspends arbitration
    busy = 1'b1;
    dev_req = 4'b1111;
    cyc();
    dev_req = '0;
    for (int k = 0; k < 3; k++) begin
      cyc();
      check("R7 busy no master", mst, 4'b0);
      check("R7 busy req held", req, 4'b1111);
    end
    busy = 1'b0;
    cyc(); check("R7 release grant", mst, 4'b1000);
    repeat (6) cyc();
    check("R7 drained", req | mst, 4'b0);

    // R9: starvation of priority 1
    starve_cnt1 = 0;
    cnt4 = 0;
    dev_req = 4'b1111;
    for (int k = 0; k < 30; k++) begin
      cyc();
      if (mst[0]) starve_cnt1++;
      if (mst[3]) cnt4++;
    end
    check("R9 priority-1 grants", 4'(starve_cnt1), 4'd0);
    check("R9 priority-4 grants", 4'(cnt4), 4'd10);
    check("R9 priority-1 still pending", req & 4'b0001, 4'b0001);
    dev_req = '0;
    repeat (8) cyc();
    check("R8 drained", req | mst, 4'b0);

    finish_run();
  end
endmodule